// File: doc/BRIEF.md
# Serial Port Register File

This block is the register set that a processor bus sees for an asynchronous serial port. A simple synchronous bus port selects one of seven byte registers by a 3-bit address: two control registers, a rate-select register, the two halves of a 16-bit bit-period register, a shared data address and a status register. Transmit and receive cores sit beside it. They report events through single-cycle strobes and take their configuration from plain output pins.

Some accesses have side effects. A write to the data address fills the transmit holding register. A read of the same address returns the last received character and clears the receive flags. A status read clears the overrun and idle flags. A write to the rate-select register reloads the bit-period register from a prescaler and a power-of-two factor, but writing the bit-period bytes directly leaves the rate-select register as it was. A single interrupt request is the registered OR of every flag whose enable is set.

Top module: `serctl_regs`

## Requirements
- R1: After reset the status register reads 0xC0, both control registers read 0x00, `clks_per_bit` is 16 and `irq` is 0. Read data appears on `bus_rdata` in the cycle after the read request. Addresses: 0 control 1, 1 control 2, 2 rate select, 3 data, 4 status, 5 bit-period high byte, 6 bit-period low byte.
- R2: A write to address 3 loads `tx_word` with {transmit ninth bit, written byte}, clears the transmit-empty flag (status bit 7) and raises `tx_pending`.
- R3: A `tx_take` pulse sets transmit-empty. A `tx_done` pulse sets transmit-complete (status bit 6). A write to address 3 clears transmit-complete.
- R4: A `rx_done` pulse while data-ready (status bit 5) is clear does four things: it stores `rx_word[7:0]` for reading at address 3, copies `rx_word[8]` to control 1 bit 7, copies `rx_frame_err` and `rx_noise` into status bits 1 and 2, and sets data-ready.
- R5: A read of address 3 returns the stored character and clears data-ready, noise and framing error.
- R6: A `rx_done` pulse while data-ready is set sets overrun (status bit 3). The stored character and the noise and framing flags stay unchanged.
- R7: A status read returns the flags as they were before the read, then clears overrun and the idle flag (status bit 4). A `line_idle` pulse sets the idle flag.
- R8: A write to address 2 stores bits [5:4] as prescaler select and bits [2:0] as rate, reads back with other bits 0, and sets `clks_per_bit` to 16 × P × 2^rate, where P is 1, 3, 4 or 13 for select values 0 to 3.
- R9: Writes to addresses 5 and 6 set `clks_per_bit[15:8]` and `[7:0]`, read back, and leave the rate-select register unchanged.
- R10: `irq` follows, one cycle later, the OR of: control 2 bit 7 with transmit-empty, bit 6 with transmit-complete, bit 5 with (data-ready or overrun), and bit 4 with idle.
- R11: Control 2 bits 3..0 drive `tx_en`, `rx_en`, `rx_wakeup` and `send_break`. Control 1 bits 1 and 0 drive `word9` and `wake_addr`, and bit 2 is the transmit ninth bit.
- R12: Control 1 bits 6..3 and status bit 0 always read 0, and control 1 bit 7 cannot be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one cycle after the request |
| tx_take | input | 1 | Transmitter took the holding register |
| tx_done | input | 1 | Transmitter finished a frame |
| tx_word | output | 9 | Holding register with ninth bit |
| tx_pending | output | 1 | Holding register full |
| rx_done | input | 1 | Receiver finished a character |
| rx_word | input | 9 | Received character |
| rx_frame_err | input | 1 | Stop bit was 0 |
| rx_noise | input | 1 | Noise seen in the character |
| line_idle | input | 1 | Receive line went idle |
| tx_en | output | 1 | Transmitter enable |
| rx_en | output | 1 | Receiver enable |
| rx_wakeup | output | 1 | Receiver standby request |
| send_break | output | 1 | Send break request |
| word9 | output | 1 | Nine data bits per frame |
| wake_addr | output | 1 | Wake by address mark rather than idle |
| clks_per_bit | output | 16 | Bit period in clock cycles |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: 8-bit data, a 16-bit bit-period register and an oversample base of 16. With these values the largest rate-select product, 16 × 13 × 128 = 26624, fits in the register without overflow, so the bench can test that upper corner next to the smallest product. It also reaches every prescaler value and a directly written bit period that no rate-select code can produce.

// File: rtl/serctl_pkg.sv
package serctl_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL1  = 3'd0,
    A_CTRL2  = 3'd1,
    A_RATE   = 3'd2,
    A_DATA   = 3'd3,
    A_STAT   = 3'd4,
    A_CPB_HI = 3'd5,
    A_CPB_LO = 3'd6
  } reg_addr_e;

  // Order matches status register bits 7..1
  typedef struct packed {
    logic tx_empty;
    logic tx_cmpl;
    logic rx_full;
    logic idle;
    logic overrun;
    logic noise;
    logic frame;
  } stat_t;

endpackage

// File: rtl/serctl_rst_sync.sv
module serctl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_out_n = sync_q[STAGES-1];
endmodule

// File: rtl/serctl_rate_map.sv
module serctl_rate_map #(
  parameter int CPB_W      = 16,
  parameter int OVERSAMPLE = 16
) (
  input  logic [1:0]       presc_sel,
  input  logic [2:0]       rate_exp,
  output logic [CPB_W-1:0] cpb
);
  logic [CPB_W-1:0] base;

  always_comb begin
    case (presc_sel)
      2'd0:    base = CPB_W'(OVERSAMPLE);
      2'd1:    base = CPB_W'(OVERSAMPLE * 3);
      2'd2:    base = CPB_W'(OVERSAMPLE * 4);
      default: base = CPB_W'(OVERSAMPLE * 13);
    endcase
    cpb = base << rate_exp;
  end
endmodule

// File: rtl/serctl_status.sv
module serctl_status
  import serctl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            data_wr,
  input  logic            data_rd,
  input  logic            stat_rd,
  input  logic            tx_take,
  input  logic            tx_done,
  input  logic            rx_done,
  input  logic [DATA_W:0] rx_word,
  input  logic            rx_frame_err,
  input  logic            rx_noise,
  input  logic            line_idle,
  output stat_t           flags,
  output logic [DATA_W:0] rx_hold
);
  stat_t            flags_d;
  logic [DATA_W:0]  hold_d;
  logic             hold_en;

  always_comb begin
    flags_d = flags;
    hold_en = 1'b0;
    // transmit side: a new write wins over a take in the same cycle
    if (data_wr) begin
      flags_d.tx_empty = 1'b0;
      flags_d.tx_cmpl  = 1'b0;
    end else begin
      if (tx_take) flags_d.tx_empty = 1'b1;
      if (tx_done) flags_d.tx_cmpl  = 1'b1;
    end
    // receive side: read clears first, arrival may refill
    if (data_rd) begin
      flags_d.rx_full = 1'b0;
      flags_d.noise   = 1'b0;
      flags_d.frame   = 1'b0;
    end
    if (stat_rd) begin
      flags_d.overrun = 1'b0;
      flags_d.idle    = 1'b0;
    end
    if (rx_done) begin
      if (flags.rx_full && !data_rd) begin
        flags_d.overrun = 1'b1;
      end else begin
        hold_en         = 1'b1;
        flags_d.rx_full = 1'b1;
        flags_d.noise   = rx_noise;
        flags_d.frame   = rx_frame_err;
      end
    end
    if (line_idle) flags_d.idle = 1'b1;
    hold_d = rx_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '{tx_empty: 1'b1, tx_cmpl: 1'b1, default: 1'b0};
    end else begin
      flags <= flags_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rx_hold <= '0;
    else if (hold_en) rx_hold <= hold_d;
  end
endmodule

// File: rtl/serctl_irq.sv
module serctl_irq
  import serctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] irq_en,
  input  stat_t      flags,
  output logic       irq
);
  logic irq_d;

  always_comb begin
    irq_d = (irq_en[3] & flags.tx_empty)
          | (irq_en[2] & flags.tx_cmpl)
          | (irq_en[1] & (flags.rx_full | flags.overrun))
          | (irq_en[0] & flags.idle);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_d;
  end
endmodule

// File: rtl/serctl_regs.sv
module serctl_regs
  import serctl_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CPB_W      = 16,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tx_take,
  input  logic              tx_done,
  output logic [DATA_W:0]   tx_word,
  output logic              tx_pending,
  input  logic              rx_done,
  input  logic [DATA_W:0]   rx_word,
  input  logic              rx_frame_err,
  input  logic              rx_noise,
  input  logic              line_idle,
  output logic              tx_en,
  output logic              rx_en,
  output logic              rx_wakeup,
  output logic              send_break,
  output logic              word9,
  output logic              wake_addr,
  output logic [CPB_W-1:0]  clks_per_bit,
  output logic              irq
);
  localparam int HALF_W = CPB_W / 2;

  logic rst_q_n;
  logic wr_hit, rd_hit;
  logic data_wr, data_rd, stat_rd;

  logic [2:0]          c1_q, c1_d;       // {t8, mode, wake}
  logic [DATA_W-1:0]   c2_q, c2_d;
  logic [1:0]          presc_q, presc_d;
  logic [2:0]          rate_q, rate_d;
  logic [CPB_W-1:0]    cpb_q, cpb_d, cpb_map;
  logic [DATA_W:0]     hold_q, hold_d;
  logic [DATA_W-1:0]   rd_mux;
  stat_t               flags;
  logic [DATA_W:0]     rx_hold;

  serctl_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_in_n(rst_n), .rst_out_n(rst_q_n)
  );

  assign wr_hit  = bus_sel &  bus_wr;
  assign rd_hit  = bus_sel & ~bus_wr;
  assign data_wr = wr_hit & (bus_addr == A_DATA);
  assign data_rd = rd_hit & (bus_addr == A_DATA);
  assign stat_rd = rd_hit & (bus_addr == A_STAT);

  serctl_rate_map #(.CPB_W(CPB_W), .OVERSAMPLE(OVERSAMPLE)) u_map (
    .presc_sel(bus_wdata[5:4]),
    .rate_exp (bus_wdata[2:0]),
    .cpb      (cpb_map)
  );

  serctl_status #(.DATA_W(DATA_W)) u_stat (
    .clk(clk), .rst_n(rst_q_n),
    .data_wr(data_wr), .data_rd(data_rd), .stat_rd(stat_rd),
    .tx_take(tx_take), .tx_done(tx_done),
    .rx_done(rx_done), .rx_word(rx_word),
    .rx_frame_err(rx_frame_err), .rx_noise(rx_noise),
    .line_idle(line_idle),
    .flags(flags), .rx_hold(rx_hold)
  );

  serctl_irq u_irq (
    .clk(clk), .rst_n(rst_q_n),
    .irq_en(c2_q[7:4]), .flags(flags), .irq(irq)
  );

  // next-state of the writable registers
  always_comb begin
    c1_d    = c1_q;
    c2_d    = c2_q;
    presc_d = presc_q;
    rate_d  = rate_q;
    cpb_d   = cpb_q;
    hold_d  = hold_q;
    if (wr_hit) begin
      case (bus_addr)
        A_CTRL1:  c1_d = bus_wdata[2:0];
        A_CTRL2:  c2_d = bus_wdata;
        A_RATE: begin
          presc_d = bus_wdata[5:4];
          rate_d  = bus_wdata[2:0];
          cpb_d   = cpb_map;
        end
        A_DATA:   hold_d = {c1_q[2], bus_wdata};
        A_CPB_HI: cpb_d[CPB_W-1:HALF_W] = bus_wdata[HALF_W-1:0];
        A_CPB_LO: cpb_d[HALF_W-1:0]     = bus_wdata[HALF_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      c1_q    <= '0;
      c2_q    <= '0;
      presc_q <= '0;
      rate_q  <= '0;
      cpb_q   <= CPB_W'(OVERSAMPLE);
      hold_q  <= '0;
    end else if (wr_hit) begin
      c1_q    <= c1_d;
      c2_q    <= c2_d;
      presc_q <= presc_d;
      rate_q  <= rate_d;
      cpb_q   <= cpb_d;
      hold_q  <= hold_d;
    end
  end

  // read path
  always_comb begin
    case (bus_addr)
      A_CTRL1:  rd_mux = {rx_hold[DATA_W], 4'b0000, c1_q};
      A_CTRL2:  rd_mux = c2_q;
      A_RATE:   rd_mux = {2'b00, presc_q, 1'b0, rate_q};
      A_DATA:   rd_mux = rx_hold[DATA_W-1:0];
      A_STAT:   rd_mux = {flags, 1'b0};
      A_CPB_HI: rd_mux = cpb_q[CPB_W-1:HALF_W];
      A_CPB_LO: rd_mux = cpb_q[HALF_W-1:0];
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)    bus_rdata <= '0;
    else if (rd_hit) bus_rdata <= rd_mux;
  end

  assign tx_word      = hold_q;
  assign tx_pending   = ~flags.tx_empty;
  assign tx_en        = c2_q[3];
  assign rx_en        = c2_q[2];
  assign rx_wakeup    = c2_q[1];
  assign send_break   = c2_q[0];
  assign word9        = c1_q[1];
  assign wake_addr    = c1_q[0];
  assign clks_per_bit = cpb_q;
endmodule

// File: rtl/serctl_regs_chk.sv
module serctl_regs_chk
  import serctl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              tx_take,
  input logic              rx_done,
  input logic              line_idle,
  input stat_t             flags,
  input logic [DATA_W:0]   rx_hold,
  input logic [1:0]        presc_q,
  input logic [2:0]        rate_q,
  input logic [3:0]        irq_en,
  input logic              irq
);
  logic d_wr, d_rd, s_rd, ovf, cond;
  assign d_wr = bus_sel &  bus_wr & (bus_addr == A_DATA);
  assign d_rd = bus_sel & ~bus_wr & (bus_addr == A_DATA);
  assign s_rd = bus_sel & ~bus_wr & (bus_addr == A_STAT);
  assign ovf  = rx_done & flags.rx_full & ~d_rd;
  assign cond = (irq_en[3] & flags.tx_empty) | (irq_en[2] & flags.tx_cmpl)
              | (irq_en[1] & (flags.rx_full | flags.overrun))
              | (irq_en[0] & flags.idle);

  // R2
  data_wr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d_wr |=> !flags.tx_empty);

  // R3
  take_sets_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_take && !d_wr) |=> flags.tx_empty);

  // R6
  overrun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (flags.overrun && $stable(rx_hold)));

  // R7
  stat_rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rd && !ovf && !line_idle) |=> (!flags.overrun && !flags.idle));

  // R9
  cpb_keeps_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && (bus_addr == A_CPB_HI || bus_addr == A_CPB_LO))
      |=> ($stable(presc_q) && $stable(rate_q)));

  // R10
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cond |=> irq);

  // R10
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cond |=> !irq);
endmodule

bind serctl_regs serctl_regs_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .tx_take(tx_take), .rx_done(rx_done),
  .line_idle(line_idle), .flags(flags), .rx_hold(rx_hold),
  .presc_q(presc_q), .rate_q(rate_q), .irq_en(c2_q[7:4]), .irq(irq)
);

// File: tb/test_serctl_regs.sv
module test_serctl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        tx_take = 1'b0, tx_done = 1'b0;
  logic [8:0]  tx_word;
  logic        tx_pending;
  logic        rx_done = 1'b0;
  logic [8:0]  rx_word = '0;
  logic        rx_frame_err = 1'b0, rx_noise = 1'b0, line_idle = 1'b0;
  logic        tx_en, rx_en, rx_wakeup, send_break, word9, wake_addr;
  logic [15:0] clks_per_bit;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_flag = 1'b0;

  always #4 clk = ~clk;

  serctl_regs i_serctl_regs (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, logic [7:0] e, string tag);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic rx(logic [8:0] w, logic fe, logic nz);
    @(negedge clk); rx_done = 1; rx_word = w; rx_frame_err = fe; rx_noise = nz;
    @(negedge clk); rx_done = 0; rx_frame_err = 0; rx_noise = 0;
  endtask

  // monitor: scoreboard side of the read path
  always @(posedge clk) rd_flag <= bus_sel && !bus_wr;
  always @(negedge clk) begin
    if (rd_flag) begin
      if (exp_q.size() == 0) chk("read with no expectation", 0, 1);
      else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    rd(3'd4, 8'hC0, "R1 status reset");
    rd(3'd0, 8'h00, "R1 ctrl1 reset");
    rd(3'd1, 8'h00, "R1 ctrl2 reset");
    chk("R1 cpb reset", clks_per_bit, 16);
    chk("R1 irq reset", irq, 0);
    // R12 unused bits
    wr(3'd0, 8'hFF);
    rd(3'd0, 8'h07, "R12 ctrl1 unused bits");
    chk("R11 word9", word9, 1);
    chk("R11 wake_addr", wake_addr, 1);
    // R2 / R3 transmit
    wr(3'd3, 8'h5A);
    chk("R2 tx_word", tx_word, 9'h15A);
    chk("R2 tx_pending", tx_pending, 1);
    rd(3'd4, 8'h00, "R2 R3 status after data write");
    @(negedge clk); tx_take = 1; @(negedge clk); tx_take = 0;
    rd(3'd4, 8'h80, "R3 take sets empty");
    @(negedge clk); tx_done = 1; @(negedge clk); tx_done = 0;
    rd(3'd4, 8'hC0, "R3 done sets complete");
    // R4 / R5 receive
    rx(9'h1A5, 1, 0);
    rd(3'd4, 8'hE2, "R4 status after receive");
    rd(3'd0, 8'h87, "R4 ninth bit in ctrl1");
    rd(3'd3, 8'hA5, "R5 data read");
    rd(3'd4, 8'hC0, "R5 flags cleared");
    // R6 / R7 overrun
    rx(9'h033, 0, 1);
    rx(9'h044, 1, 0);
    rd(3'd4, 8'hEC, "R6 overrun set flags kept");
    rd(3'd4, 8'hE4, "R7 overrun cleared by status read");
    rd(3'd3, 8'h33, "R6 first char kept");
    rd(3'd4, 8'hC0, "R6 cleared");
    @(negedge clk); line_idle = 1; @(negedge clk); line_idle = 0;
    rd(3'd4, 8'hD0, "R7 idle set");
    rd(3'd4, 8'hC0, "R7 idle cleared");
    // R8 rate select
    wr(3'd2, 8'h25);
    chk("R8 cpb 4x32", clks_per_bit, 2048);
    rd(3'd2, 8'h25, "R8 rate readback");
    wr(3'd2, 8'hFF);
    chk("R8 cpb max", clks_per_bit, 26624);
    rd(3'd2, 8'h37, "R8 rate readback masked");
    wr(3'd2, 8'h10);
    chk("R8 cpb 3x1", clks_per_bit, 48);
    // R9 direct bit period
    wr(3'd5, 8'h12);
    wr(3'd6, 8'h34);
    chk("R9 cpb direct", clks_per_bit, 16'h1234);
    rd(3'd2, 8'h10, "R9 rate unchanged");
    rd(3'd5, 8'h12, "R9 high byte");
    rd(3'd6, 8'h34, "R9 low byte");
    // R10 interrupt
    wr(3'd1, 8'h80); @(negedge clk);
    chk("R10 irq tx empty", irq, 1);
    wr(3'd1, 8'h20); @(negedge clk);
    chk("R10 irq rx idle low", irq, 0);
    rx(9'h055, 0, 0); @(negedge clk);
    chk("R10 irq rx ready", irq, 1);
    rd(3'd3, 8'h55, "R10 R5 data read");
    @(negedge clk);
    chk("R10 irq drops on read", irq, 0);
    wr(3'd1, 8'h10);
    @(negedge clk); line_idle = 1; @(negedge clk); line_idle = 0; @(negedge clk);
    chk("R10 irq idle", irq, 1);
    rd(3'd4, 8'hD0, "R10 R7 idle status");
    @(negedge clk);
    chk("R10 irq idle cleared", irq, 0);
    // R11 control outputs
    wr(3'd1, 8'h0F);
    chk("R11 outputs", {tx_en, rx_en, rx_wakeup, send_break}, 4'hF);
    wr(3'd1, 8'h05);
    chk("R11 outputs pattern", {tx_en, rx_en, rx_wakeup, send_break}, 4'h5);
    repeat (3) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule